// File: doc/BRIEF.md
# Self-Timed Parallel EEPROM Bus Front End

This block is a clocked model of a byte-wide nonvolatile memory. To the host it looks like an asynchronous static RAM. The host drives three active-low strobes (chip select, output enable and write strobe), an 11-bit address and an 8-bit data input. The block returns read data with a drive-enable flag. The strobes and the clear flag pass through a two-flop synchronizer, and all edge decisions are made on the synchronized copies.

A write pulse captures the target address when both strobes have become low. It captures the data when the first of the two strobes returns high. After that the block runs a self-timed cycle: it first erases the byte to all ones and then programs the new value. While that cycle runs, any enabled read returns a polling word, and new write pulses are ignored.

Writes are inhibited in four cases: while output enable is low, while the supply-good input has not been high long enough, during a busy cycle, and while the clear flag is raised. A long write-strobe pulse given with the clear flag raised sets the whole storage to all ones. A 32-byte identification area sits behind the top 32 addresses when the identification select input is high.

Top module: `pbus_nvm`

## Requirements
- R1: With ce_n=0, oe_n=0 and we_n=1 held, dout_en is 1 two clocks after the strobes settle. While no write cycle is running, dout then equals the byte stored at the addressed location.
- R2: dout_en is 0 whenever the synchronized ce_n or oe_n is 1, or the synchronized we_n is 0. It is also 0 out of reset.
- R3: A write is accepted either as a we_n low pulse while ce_n is low or as a ce_n low pulse while we_n is low, provided oe_n stays 1. After the cycle completes, the location reads back the written byte.
- R4: The address is taken when the later of the two strobes falls. The data is taken when the earlier of the two strobes rises. Both are seen through the two-clock synchronizer. Changing addr after the capture, or changing din after the rising strobe has been seen, does not alter the stored result.
- R5: A write cycle keeps the block busy for exactly WRITE_CYC clocks. It erases the byte to 8'hFF and then programs it, so the final content equals the written byte whatever the previous content was.
- R6: While busy, an enabled read at any address returns the inverted bit 7 of the byte being written on bit 7, and 7'h2A on bits 6..0 (bit i is 1 when i is odd).
- R7: Write pulses that arrive while busy are ignored: neither the addressed location nor the cycle in progress changes.
- R8: A write strobe pulse given while oe_n is 0 changes nothing.
- R9: Writes and clears are ignored until supply_ok has been 1 for PWRUP_CYC consecutive clocks. A clock with supply_ok=0 restarts this lockout.
- R10: With hv_clear=1 and ce_n=0, a we_n low pulse lasting at least CLEAR_CYC synchronized clocks sets every byte of the main array and of the identification area to 8'hFF when we_n rises.
- R11: A clear pulse shorter than CLEAR_CYC clocks leaves the contents unchanged.
- R12: With hv_id=1, addresses whose upper six bits are all ones (0x7E0..0x7FF) read and write a separate 32-byte area indexed by addr[4:0]. With hv_id=0 the same addresses reach the main array. With hv_id=1, other addresses also reach the main array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, starts the power-up lockout timer |
| ce_n | input | 1 | Active-low chip select strobe |
| oe_n | input | 1 | Active-low output enable strobe |
| we_n | input | 1 | Active-low write strobe |
| hv_clear | input | 1 | High-voltage flag on output enable; selects whole-array clear |
| hv_id | input | 1 | High-voltage identification select |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data or polling word |
| dout_en | output | 1 | Drive enable for dout |

## Verification
The assertions assume two things about the host. First, the strobes stay at their inactive levels while reset is applied. Second, addr and din stay stable for at least two clocks around each strobe edge, because they are sampled without a synchronizer. The properties that compare dout_en with strobe values from two clocks earlier only start once three clocks have passed since reset. The stimulus changes inputs only on falling clock edges and holds every strobe level for at least four clocks. It waits for a full write cycle before the next accepted write, except where a write is deliberately sent into a busy window.

// File: rtl/nvm_pkg.sv
// Shared types for the parallel EEPROM front end.
// Assumes nothing beyond the users importing it.
package nvm_pkg;

    // Write sequencer states: idle, address captured, erase phase, program phase.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ERASE = 2'd2,
        ST_PROG  = 2'd3
    } wr_state_t;

endpackage

// File: rtl/nvm_strobe_sync.sv
// Two-flop synchronizer for a vector of asynchronous control levels.
// Assumes each bit is a slowly changing level; RST_VAL gives the inactive level.
module nvm_strobe_sync #(
    parameter int            W       = 4,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages per bit, forced to the inactive level in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    assign sync = sync_q;

endmodule

// File: rtl/nvm_store.sv
// Storage for the main byte array and the identification area.
// Assumes a single write per clock; a clear request takes priority over a write.
// The contents are nonvolatile in the model, so they have no reset.
module nvm_store #(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int ID_DEPTH = 32
) (
    input  logic          clk,
    input  logic          clr_all,
    input  logic          wr_en,
    input  logic          wr_id,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_id,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;
    localparam int IDW   = $clog2(ID_DEPTH);

    logic [DW-1:0] main_mem [DEPTH];
    logic [DW-1:0] id_mem   [ID_DEPTH];

    // Whole-array clear, or a single byte update in the selected area.
    always_ff @(posedge clk) begin
        if (clr_all) begin
            for (int i = 0; i < DEPTH; i++) main_mem[i] <= '1;
            for (int j = 0; j < ID_DEPTH; j++) id_mem[j] <= '1;
        end else if (wr_en) begin
            if (wr_id) id_mem[wr_addr[IDW-1:0]] <= wr_data;
            else       main_mem[wr_addr]        <= wr_data;
        end
    end

    // Asynchronous read of the selected area.
    always_comb begin
        if (rd_id) rd_data = id_mem[rd_addr[IDW-1:0]];
        else       rd_data = main_mem[rd_addr];
    end

endmodule

// File: rtl/nvm_seq.sv
// Write and clear sequencer. It holds the power-up lockout, captures the
// address and data of a write pulse, runs the erase/program timer and
// recognises a long clear pulse.
// Assumes the strobes are already synchronized and addr/din are stable
// around the synchronized edges.
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int AW        = 11,
    parameter int DW        = 8,
    parameter int WRITE_CYC = 10000,
    parameter int PWRUP_CYC = 250000,
    parameter int CLEAR_CYC = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic          we_s,
    input  logic          hv_s,
    input  logic [AW-1:0] addr,
    input  logic          id_hit,
    input  logic [DW-1:0] din,
    output logic          busy,
    output logic [DW-1:0] wr_data,
    output logic          mem_we,
    output logic          mem_id,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          clr_all
);

    localparam int TW = (WRITE_CYC > 2) ? $clog2(WRITE_CYC) : 1;
    localparam int PW = $clog2(PWRUP_CYC + 1);
    localparam int CW = $clog2(CLEAR_CYC + 1);
    localparam int ERASE_CYC = WRITE_CYC / 2;
    localparam logic [TW-1:0] ERASE_LAST = TW'(ERASE_CYC - 1);
    localparam logic [TW-1:0] WRITE_LAST = TW'(WRITE_CYC - 1);
    localparam logic [PW-1:0] PU_DONE    = PW'(PWRUP_CYC);
    localparam logic [CW-1:0] CLR_DONE   = CW'(CLEAR_CYC);

    wr_state_t     st_q;
    logic [TW-1:0] tcnt_q;
    logic [PW-1:0] pu_cnt_q;
    logic [CW-1:0] clr_cnt_q;
    logic [AW-1:0] lat_addr_q;
    logic          lat_id_q;
    logic [DW-1:0] lat_data_q;
    logic          act_q;
    logic          we_q;
    logic          ready;
    logic          act;
    logic          act_rise;
    logic          clr_lvl;

    assign ready    = (pu_cnt_q == PU_DONE);
    assign act      = !ce_s && !we_s;
    assign act_rise = act && !act_q;
    assign clr_lvl  = !ce_s && !we_s && hv_s && ready && (st_q == ST_IDLE);

    // Power-up lockout: count consecutive supply-good clocks up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok)  pu_cnt_q <= '0;
        else if (!ready)           pu_cnt_q <= pu_cnt_q + 1'b1;
    end

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            we_q  <= 1'b1;
        end else begin
            act_q <= act;
            we_q  <= we_s;
        end
    end

    // Write sequencer: capture the address, capture the data, then erase and program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            tcnt_q     <= '0;
            lat_addr_q <= '0;
            lat_id_q   <= 1'b0;
            lat_data_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (act_rise && oe_s && !hv_s && ready) begin
                        lat_addr_q <= addr;
                        lat_id_q   <= id_hit;
                        st_q       <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (!ready || !oe_s || hv_s) begin
                        st_q <= ST_IDLE;
                    end else if (!act) begin
                        lat_data_q <= din;
                        tcnt_q     <= '0;
                        st_q       <= ST_ERASE;
                    end
                end
                ST_ERASE: begin
                    tcnt_q <= tcnt_q + 1'b1;
                    if (tcnt_q == ERASE_LAST) st_q <= ST_PROG;
                end
                ST_PROG: begin
                    if (tcnt_q == WRITE_LAST) begin
                        tcnt_q <= '0;
                        st_q   <= ST_IDLE;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Clear pulse length counter, saturating at the required length.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_lvl)     clr_cnt_q <= '0;
        else if (clr_cnt_q != CLR_DONE) clr_cnt_q <= clr_cnt_q + 1'b1;
    end

    // Storage requests: erase at the first busy clock, program at the last one.
    always_comb begin
        busy      = (st_q == ST_ERASE) || (st_q == ST_PROG);
        mem_we    = ((st_q == ST_ERASE) && (tcnt_q == '0)) ||
                    ((st_q == ST_PROG) && (tcnt_q == WRITE_LAST));
        mem_wdata = (st_q == ST_ERASE) ? '1 : lat_data_q;
        mem_addr  = lat_addr_q;
        mem_id    = lat_id_q;
        wr_data   = lat_data_q;
        clr_all   = (clr_cnt_q == CLR_DONE) && we_s && !we_q && !ce_s && hv_s;
    end

endmodule

// File: rtl/pbus_nvm.sv
// Top level of the self-timed parallel EEPROM front end. It synchronizes
// the host strobes, decodes the identification window, and selects between
// stored data and the polling word for reads.
// Assumes addr and din are held stable around the strobe edges by the host.
module pbus_nvm #(
    parameter int AW        = 11,
    parameter int DW        = 8,
    parameter int ID_DEPTH  = 32,
    parameter int WRITE_CYC = 10000,
    parameter int PWRUP_CYC = 250000,
    parameter int CLEAR_CYC = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          hv_clear,
    input  logic          hv_id,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    localparam int IDW = $clog2(ID_DEPTH);

    logic [3:0]    strb_s;
    logic          ce_s, oe_s, we_s, hv_s;
    logic          id_hit;
    logic          busy;
    logic [DW-1:0] wr_data;
    logic          mem_we, mem_id, clr_all;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] rd_data;

    nvm_strobe_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({hv_clear, we_n, oe_n, ce_n}),
        .sync (strb_s)
    );

    assign ce_s = strb_s[0];
    assign oe_s = strb_s[1];
    assign we_s = strb_s[2];
    assign hv_s = strb_s[3];

    // Identification window: select raised and upper address bits all ones.
    assign id_hit = hv_id && (addr[AW-1:IDW] == '1);

    nvm_seq #(
        .AW(AW), .DW(DW), .WRITE_CYC(WRITE_CYC),
        .PWRUP_CYC(PWRUP_CYC), .CLEAR_CYC(CLEAR_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .ce_s     (ce_s),
        .oe_s     (oe_s),
        .we_s     (we_s),
        .hv_s     (hv_s),
        .addr     (addr),
        .id_hit   (id_hit),
        .din      (din),
        .busy     (busy),
        .wr_data  (wr_data),
        .mem_we   (mem_we),
        .mem_id   (mem_id),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .clr_all  (clr_all)
    );

    nvm_store #(.AW(AW), .DW(DW), .ID_DEPTH(ID_DEPTH)) u_store (
        .clk    (clk),
        .clr_all(clr_all),
        .wr_en  (mem_we),
        .wr_id  (mem_id),
        .wr_addr(mem_addr),
        .wr_data(mem_wdata),
        .rd_id  (id_hit),
        .rd_addr(addr),
        .rd_data(rd_data)
    );

    // Read enable from the synchronized strobes.
    assign dout_en = !ce_s && !oe_s && we_s;

    // Read data: stored byte, or the polling word while a write cycle runs.
    always_comb begin
        if (busy) begin
            dout[DW-1] = ~wr_data[DW-1];
            for (int i = 0; i < DW - 1; i++) dout[i] = (i % 2 == 1);
        end else begin
            dout = rd_data;
        end
    end

endmodule

// File: rtl/pbus_nvm_chk.sv
// Property checker for the parallel EEPROM front end, bound into the top.
// Assumes strobes are inactive during reset.
module pbus_nvm_chk #(
    parameter int DW        = 8,
    parameter int WRITE_CYC = 10000,
    parameter int PWRUP_CYC = 250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          busy,
    input  logic          dout_en,
    input  logic [DW-1:0] dout,
    input  logic [DW-1:0] wr_data
);

    logic [1:0] age_q;
    int         busy_run_q;
    int         sup_run_q;
    logic       warm;

    assign warm = (age_q == 2'd3);

    // Clocks since reset, saturating, so two-deep history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= '0;
        else if (!warm)       age_q <= age_q + 1'b1;
    end

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run_q <= 0;
        else                 busy_run_q <= busy_run_q + 1;
    end

    // Consecutive supply-good clocks, saturating at the lockout length.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok)     sup_run_q <= 0;
        else if (sup_run_q < PWRUP_CYC) sup_run_q <= sup_run_q + 1;
    end

    // R1: a read strobe pattern two clocks back enables the outputs.
    a_r1_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(ce_n, 2) && !$past(oe_n, 2) && $past(we_n, 2)) |-> dout_en);

    // R2: chip select high two clocks back keeps the outputs floating.
    a_r2_float_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(ce_n, 2)) |-> !dout_en);

    // R2: output enable high two clocks back keeps the outputs floating.
    a_r2_float_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(oe_n, 2)) |-> !dout_en);

    // R5: every busy run lasts exactly the write cycle length.
    a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run_q == WRITE_CYC));

    // R6: polling bit 7 is the inverse of the byte being written.
    a_r6_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dout_en) |-> (dout[DW-1] == ~wr_data[DW-1]));

    // R7: latched write data does not move during a busy cycle.
    a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wr_data));

    // R9: a write cycle starts only after the full supply-good lockout.
    a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(sup_run_q) == PWRUP_CYC));

endmodule

bind pbus_nvm pbus_nvm_chk #(
    .DW(DW), .WRITE_CYC(WRITE_CYC), .PWRUP_CYC(PWRUP_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .busy     (busy),
    .dout_en  (dout_en),
    .dout     (dout),
    .wr_data  (wr_data)
);

// File: tb/pbus_nvm_bench.sv
// Self-checking bench for pbus_nvm: directed corner cases followed by seeded
// random reads and writes compared against a bench-side byte model.
module pbus_nvm_bench;

    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int WCYC  = 40;
    localparam int PUCYC = 200;
    localparam int CLCYC = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          hv_clear = 1'b0, hv_id = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [DW-1:0] mdl_main [1 << AW];
    logic [DW-1:0] mdl_id   [32];

    always #10 clk = ~clk;

    pbus_nvm #(
        .AW(AW), .DW(DW), .ID_DEPTH(32),
        .WRITE_CYC(WCYC), .PWRUP_CYC(PUCYC), .CLEAR_CYC(CLCYC)
    ) u_pbus_nvm (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hv_clear(hv_clear), .hv_id(hv_id),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic is_id(input logic [AW-1:0] a, input logic sel);
        return sel && (a[AW-1:5] == '1);
    endfunction

    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a, input logic sel);
        return is_id(a, sel) ? mdl_id[a[4:0]] : mdl_main[a];
    endfunction

    function automatic logic [DW-1:0] poll_word(input logic [DW-1:0] d);
        return {~d[7], 7'h2A};
    endfunction

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got en/data %b_%h, expected %b_%h",
                     req, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    // Read cycle: returns {dout_en, dout} sampled once the strobes have synchronized.
    task automatic rd(input logic [AW-1:0] a, input logic sel, output logic [DW:0] r);
        addr = a; hv_id = sel;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        cyc(4);
        r = {dout_en, dout};
        bus_idle();
        cyc(3);
    endtask

    // Write strobe controlled write.
    task automatic wr_we(input logic [AW-1:0] a, input logic sel, input logic [DW-1:0] d);
        addr = a; hv_id = sel; din = d;
        oe_n = 1'b1; ce_n = 1'b0;
        cyc(2);
        we_n = 1'b0;
        cyc(4);
        we_n = 1'b1;
        cyc(4);
        ce_n = 1'b1;
        cyc(2);
    endtask

    // Chip select controlled write.
    task automatic wr_ce(input logic [AW-1:0] a, input logic sel, input logic [DW-1:0] d);
        addr = a; hv_id = sel; din = d;
        oe_n = 1'b1; we_n = 1'b0;
        cyc(2);
        ce_n = 1'b0;
        cyc(4);
        ce_n = 1'b1;
        cyc(4);
        we_n = 1'b1;
        cyc(2);
    endtask

    task automatic settle();
        cyc(WCYC + 10);
    endtask

    task automatic clear_pulse(input int len);
        hv_clear = 1'b1; oe_n = 1'b1;
        cyc(3);
        ce_n = 1'b0;
        cyc(2);
        we_n = 1'b0;
        cyc(len);
        we_n = 1'b1;
        cyc(4);
        ce_n = 1'b1;
        cyc(2);
        hv_clear = 1'b0;
        cyc(3);
    endtask

    task automatic model_clear();
        for (int i = 0; i < (1 << AW); i++) mdl_main[i] = '1;
        for (int i = 0; i < 32; i++) mdl_id[i] = '1;
    endtask

    task automatic model_wr(input logic [AW-1:0] a, input logic sel, input logic [DW-1:0] d);
        if (is_id(a, sel)) mdl_id[a[4:0]] = d;
        else               mdl_main[a] = d;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW:0] r;
        void'($urandom(32'd4242));

        // Reset state: outputs not driven.
        cyc(5);
        check("R2 reset", {dout_en, dout}, {1'b0, dout});
        rst_n = 1'b1;

        // Let the power-up lockout expire, then clear to a known state.
        cyc(PUCYC + 10);
        clear_pulse(CLCYC + 10);
        model_clear();
        rd(11'h000, 1'b0, r); check("R10 main low", r, {1'b1, 8'hFF});
        rd(11'h5A3, 1'b0, r); check("R10 main mid", r, {1'b1, 8'hFF});
        rd(11'h7FF, 1'b1, r); check("R10 id top", r, {1'b1, 8'hFF});

        // R3 write strobe write, then short clear pulse R11.
        wr_we(11'h005, 1'b0, 8'h33); model_wr(11'h005, 1'b0, 8'h33);
        settle();
        rd(11'h005, 1'b0, r); check("R3 we-controlled", r, {1'b1, 8'h33});
        clear_pulse(CLCYC - 10);
        rd(11'h005, 1'b0, r); check("R11 short clear", r, {1'b1, 8'h33});

        // R6 polling with bit 7 low, R7 write during busy, R5 overwrite.
        wr_we(11'h005, 1'b0, 8'h3C); model_wr(11'h005, 1'b0, 8'h3C);
        rd(11'h123, 1'b0, r); check("R6 poll b7=0", r, {1'b1, poll_word(8'h3C)});
        wr_we(11'h200, 1'b0, 8'h99);
        settle();
        rd(11'h005, 1'b0, r); check("R5 erase then program", r, {1'b1, 8'h3C});
        rd(11'h200, 1'b0, r); check("R7 busy write ignored", r, {1'b1, 8'hFF});

        // R6 polling with bit 7 high.
        wr_we(11'h006, 1'b0, 8'hC3); model_wr(11'h006, 1'b0, 8'hC3);
        rd(11'h006, 1'b0, r); check("R6 poll b7=1", r, {1'b1, poll_word(8'hC3)});
        settle();
        rd(11'h006, 1'b0, r); check("R1 true data after cycle", r, {1'b1, 8'hC3});

        // R8 write pulse with output enable low.
        addr = 11'h006; din = 8'h00; hv_id = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0;
        cyc(2); we_n = 1'b0; cyc(4); we_n = 1'b1; cyc(4);
        bus_idle(); settle();
        rd(11'h006, 1'b0, r); check("R8 oe low inhibits", r, {1'b1, 8'hC3});

        // R3 chip select controlled write.
        wr_ce(11'h3F0, 1'b0, 8'h5E); model_wr(11'h3F0, 1'b0, 8'h5E);
        settle();
        rd(11'h3F0, 1'b0, r); check("R3 ce-controlled", r, {1'b1, 8'h5E});

        // R4 capture points: address moves after the fall, data after the rise.
        addr = 11'h111; din = 8'hA7; hv_id = 1'b0; oe_n = 1'b1; ce_n = 1'b0;
        cyc(4);
        addr = 11'h222; we_n = 1'b0;
        cyc(4);
        addr = 11'h111;
        cyc(2);
        we_n = 1'b1;
        cyc(5);
        din = 8'h00;
        cyc(2);
        bus_idle(); settle();
        model_wr(11'h222, 1'b0, 8'hA7);
        rd(11'h222, 1'b0, r); check("R4 later-fall address", r, {1'b1, 8'hA7});
        rd(11'h111, 1'b0, r); check("R4 other address untouched", r, {1'b1, 8'hFF});

        // R2 float cases.
        addr = 11'h222; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; cyc(4);
        check("R2 oe high floats", {dout_en, 8'h00}, 9'h000);
        ce_n = 1'b1; oe_n = 1'b0; cyc(4);
        check("R2 ce high floats", {dout_en, 8'h00}, 9'h000);
        bus_idle(); cyc(3);

        // R12 identification area.
        wr_we(11'h7E5, 1'b1, 8'h81); model_wr(11'h7E5, 1'b1, 8'h81);
        settle();
        rd(11'h7E5, 1'b1, r); check("R12 id read", r, {1'b1, 8'h81});
        rd(11'h7E5, 1'b0, r); check("R12 main behind id", r, {1'b1, 8'hFF});
        wr_we(11'h100, 1'b1, 8'h42); model_wr(11'h100, 1'b1, 8'h42);
        settle();
        rd(11'h100, 1'b0, r); check("R12 select outside window", r, {1'b1, 8'h42});

        // R9 supply drop restarts the lockout.
        supply_ok = 1'b0; cyc(1); supply_ok = 1'b1;
        wr_we(11'h010, 1'b0, 8'h55);
        settle();
        rd(11'h010, 1'b0, r); check("R9 write in lockout", r, {1'b1, 8'hFF});
        clear_pulse(CLCYC + 10);
        rd(11'h005, 1'b0, r); check("R9 clear in lockout", r, {1'b1, 8'h3C});
        cyc(PUCYC);

        // Random mix of reads and writes against the model (R1, R3, R12).
        for (int k = 0; k < 100; k++) begin
            logic [AW-1:0] ra;
            logic          rs;
            logic [DW-1:0] rdv;
            ra  = AW'($urandom);
            if ($urandom % 3 == 0) ra[AW-1:5] = '1;
            rs  = ($urandom % 2) == 1;
            rdv = DW'($urandom);
            if ($urandom % 2 == 0) begin
                wr_we(ra, rs, rdv); model_wr(ra, rs, rdv);
                settle();
            end
            rd(ra, rs, r);
            check("R1 random read", r, {1'b1, model_rd(ra, rs)});
        end

        // R10 final clear wipes everything including the id area.
        clear_pulse(CLCYC + 10);
        model_clear();
        rd(11'h7E5, 1'b1, r); check("R10 id cleared", r, {1'b1, 8'hFF});
        rd(11'h222, 1'b0, r); check("R10 main cleared", r, {1'b1, 8'hFF});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule